// File: doc/BRIEF.md
# ADC Output Settling Mute and Overload Monitor

This block sits behind the decimation chain of a stereo audio ADC. It holds the serial output muted after reset, after power-down recovery and after a restart of the system clock, so that unsettled filter output never leaves the converter. The settling window is counted in sample periods. It is long when the DC-removal high-pass filter is in the path and short when that filter is bypassed.

It also watches the left and right samples for values near digital full scale. On an excursion it raises an overflow flag and holds the flag for a fixed number of sample periods. Every new excursion restarts that hold. The filters themselves are not part of the block. It only sees a sample strobe, the two channel words, the filter-enable level and a restart pulse.

Top module: `adc_settle_guard`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `mute_o` is 1 and `ovf_o` is 0.
- R2: With `dc_cut_en_i` = 0, `mute_o` stays 1 through the first MUTE_SHORT-1 strobes and goes to 0 in the cycle after the MUTE_SHORT-th strobe.
- R3: With `dc_cut_en_i` = 1, the same holds with MUTE_LONG strobes.
- R4: A cycle with `restart_i` = 1 reloads the settling count for the current mode and forces `mute_o` to 1 from the next cycle. A strobe in that same cycle is not counted.
- R5: A change of `dc_cut_en_i` while muted reloads the count with the new mode's length, and a strobe in that cycle is not counted. A change after the mute has ended leaves `mute_o` at 0.
- R6: Cycles without `smp_vld_i` = 1 advance neither the settling count nor the overflow hold.
- R7: Samples are signed two's complement, SMP_W bits wide. A strobe with either channel's magnitude above 7*2^(SMP_W-4) (7/8 of full scale) sets `ovf_o` to 1 in the next cycle. A magnitude equal to that value does not.
- R8: After the last overload strobe, `ovf_o` stays 1 through OVF_HOLD further strobes and falls in the cycle after the OVF_HOLD-th one. Each new overload restarts the hold.
- R9: While `mute_o` is 1, overloads are ignored and `ovf_o` is 0. Entering mute clears a running hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_vld_i | input | 1 | One-cycle strobe per output sample period |
| left_i | input | SMP_W | Left sample, signed |
| right_i | input | SMP_W | Right sample, signed |
| dc_cut_en_i | input | 1 | DC-removal filter enabled (selects long settling) |
| restart_i | input | 1 | Power-down recovery or clock restart pulse |
| mute_o | output | 1 | Output must be held low |
| ovf_o | output | 1 | Overload flag |

## Verification
The bench builds the block with SMP_W = 8, MUTE_SHORT = 8, MUTE_LONG = 20 and OVF_HOLD = 5. With these values both settling windows, several full hold periods and retriggers fall within a few hundred cycles. The 8-bit samples put the threshold at 112, so the edges 112, 113, -112, -113, -128 and 127 can be driven exactly. The default lengths use the same counter logic with wider registers.

// File: rtl/adc_guard_pkg.sv
package adc_guard_pkg;
  localparam int unsigned N_CH = 2;

  // magnitude above 7/8 of full scale (about -1.16 dB)
  function automatic int unsigned near_full_th(int unsigned w);
    return 7 << (w - 4);
  endfunction
endpackage

// File: rtl/adc_peak_detect.sv
module adc_peak_detect
  import adc_guard_pkg::*;
#(
  parameter int unsigned SMP_W = 20
) (
  input  logic [SMP_W-1:0] smp_i,
  output logic             hit_o
);
  localparam int unsigned  MW = SMP_W + 1;
  localparam logic [MW-1:0] TH = MW'(near_full_th(SMP_W));

  logic [MW-1:0] ext;
  logic [MW-1:0] mag;

  assign ext   = {smp_i[SMP_W-1], smp_i};
  assign mag   = smp_i[SMP_W-1] ? (~ext + 1'b1) : ext;
  assign hit_o = mag > TH;
endmodule

// File: rtl/adc_settle_timer.sv
module adc_settle_timer #(
  parameter int unsigned MUTE_SHORT = 1024,
  parameter int unsigned MUTE_LONG  = 12288
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vld_i,
  input  logic dc_en_i,
  input  logic restart_i,
  output logic mute_o
);
  localparam int unsigned MAXL = (MUTE_LONG > MUTE_SHORT) ? MUTE_LONG : MUTE_SHORT;
  localparam int unsigned CW   = $clog2(MAXL + 1);
  localparam logic [CW-1:0] SHORT_V = CW'(MUTE_SHORT);
  localparam logic [CW-1:0] LONG_V  = CW'(MUTE_LONG);

  logic [CW-1:0] cnt_q;
  logic          dc_q;
  logic [CW-1:0] load_v;
  logic          mode_chg;

  assign load_v   = dc_en_i ? LONG_V : SHORT_V;
  assign mode_chg = (dc_en_i != dc_q) && (cnt_q != '0);
  assign mute_o   = cnt_q != '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= SHORT_V;
      dc_q  <= 1'b0;
    end else begin
      dc_q <= dc_en_i;
      if (restart_i || mode_chg) cnt_q <= load_v;
      else if (vld_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  logic up_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) up_q <= 1'b0;
    else         up_q <= 1'b1;

  a_r4_restart_mutes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> mute_o);
  a_r4_rise_needs_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_q && mute_o && !$past(mute_o)) |-> $past(restart_i));
  a_r6_release_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_q && !mute_o && $past(mute_o)) |-> $past(vld_i));
endmodule

// File: rtl/adc_ovf_hold.sv
module adc_ovf_hold #(
  parameter int unsigned OVF_HOLD = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vld_i,
  input  logic hit_i,
  input  logic mute_i,
  output logic ovf_o
);
  localparam int unsigned HW = $clog2(OVF_HOLD + 1);
  localparam logic [HW-1:0] HOLD_V = HW'(OVF_HOLD);

  logic [HW-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   hold_q <= '0;
    else if (mute_i)               hold_q <= '0;
    else if (vld_i && hit_i)       hold_q <= HOLD_V;
    else if (vld_i && hold_q != '0) hold_q <= hold_q - 1'b1;
  end

  assign ovf_o = (hold_q != '0) && !mute_i;

  logic up_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) up_q <= 1'b0;
    else         up_q <= 1'b1;

  a_r7_hit_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && hit_i && !mute_i) |=> (ovf_o || mute_i));
  a_r6_rise_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_q && ovf_o && !$past(ovf_o)) |-> $past(vld_i));
endmodule

// File: rtl/adc_settle_guard.sv
module adc_settle_guard
  import adc_guard_pkg::*;
#(
  parameter int unsigned SMP_W      = 20,
  parameter int unsigned MUTE_SHORT = 1024,
  parameter int unsigned MUTE_LONG  = 12288,
  parameter int unsigned OVF_HOLD   = 512
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_vld_i,
  input  logic [SMP_W-1:0] left_i,
  input  logic [SMP_W-1:0] right_i,
  input  logic             dc_cut_en_i,
  input  logic             restart_i,
  output logic             mute_o,
  output logic             ovf_o
);
  logic [SMP_W-1:0] smp [N_CH];
  logic [N_CH-1:0]  hit;

  assign smp[0] = left_i;
  assign smp[1] = right_i;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    adc_peak_detect #(.SMP_W(SMP_W)) u_det (
      .smp_i (smp[ch]),
      .hit_o (hit[ch])
    );
  end

  adc_settle_timer #(
    .MUTE_SHORT (MUTE_SHORT),
    .MUTE_LONG  (MUTE_LONG)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vld_i     (smp_vld_i),
    .dc_en_i   (dc_cut_en_i),
    .restart_i (restart_i),
    .mute_o    (mute_o)
  );

  adc_ovf_hold #(.OVF_HOLD(OVF_HOLD)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (smp_vld_i),
    .hit_i  (|hit),
    .mute_i (mute_o),
    .ovf_o  (ovf_o)
  );

  logic up_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) up_q <= 1'b0;
    else         up_q <= 1'b1;

  a_r9_quiet_after_mute: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_q && $past(mute_o)) |-> !ovf_o);
endmodule

// File: tb/tb_adc_settle_guard.sv
module tb_adc_settle_guard;
  localparam int W = 8;
  localparam int NS = 8;
  localparam int NL = 20;
  localparam int NH = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0;
  logic [W-1:0] left = '0;
  logic [W-1:0] right = '0;
  logic dc = 1'b0;
  logic rst_pulse = 1'b0;
  logic mute, ovf;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  adc_settle_guard #(
    .SMP_W(W), .MUTE_SHORT(NS), .MUTE_LONG(NL), .OVF_HOLD(NH)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .smp_vld_i(vld), .left_i(left),
    .right_i(right), .dc_cut_en_i(dc), .restart_i(rst_pulse),
    .mute_o(mute), .ovf_o(ovf)
  );

  // {left, right, expected ovf}, walked after the short mute ends
  localparam logic [16:0] VEC [21] = '{
    {8'h00, 8'h00, 1'b0}, {8'h70, 8'h00, 1'b0}, {8'h00, 8'h90, 1'b0},
    {8'h71, 8'h00, 1'b1}, {8'h00, 8'h00, 1'b1}, {8'h00, 8'h00, 1'b1},
    {8'h00, 8'h00, 1'b1}, {8'h00, 8'h8F, 1'b1}, {8'h00, 8'h00, 1'b1},
    {8'h00, 8'h00, 1'b1}, {8'h00, 8'h00, 1'b1}, {8'h00, 8'h00, 1'b1},
    {8'h00, 8'h00, 1'b0}, {8'h80, 8'h00, 1'b1}, {8'h7F, 8'h7F, 1'b1},
    {8'h00, 8'h00, 1'b1}, {8'h00, 8'h00, 1'b1}, {8'h00, 8'h00, 1'b1},
    {8'h00, 8'h00, 1'b1}, {8'h00, 8'h00, 1'b0}, {8'h90, 8'h70, 1'b0}
  };

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // one strobe; returns at the negedge after the consuming edge
  task automatic strobe(logic [W-1:0] l, logic [W-1:0] r);
    @(negedge clk);
    vld = 1'b1; left = l; right = r;
    @(negedge clk);
    vld = 1'b0; left = '0; right = '0;
  endtask

  task automatic strobes(int n);
    for (int i = 0; i < n; i++) strobe('0, '0);
  endtask

  task automatic restart(bit with_vld);
    @(negedge clk);
    rst_pulse = 1'b1; vld = with_vld;
    @(negedge clk);
    rst_pulse = 1'b0; vld = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 mute in reset", int'(mute), 1);
    check("R1 ovf in reset", int'(ovf), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 mute after reset", int'(mute), 1);
    check("R1 ovf after reset", int'(ovf), 0);

    // short window, idle cycles and ignored overload while muted
    strobes(3);
    strobe(8'h7F, 8'h80);
    check("R9 overload ignored in mute", int'(ovf), 0);
    repeat (12) @(negedge clk);
    check("R6 idle keeps mute", int'(mute), 1);
    strobes(NS - 5);
    check("R2 mute before last strobe", int'(mute), 1);
    strobe('0, '0);
    check("R2 mute released", int'(mute), 0);
    check("R9 no stale overload", int'(ovf), 0);

    // threshold and hold table
    for (int i = 0; i < 21; i++) begin
      strobe(VEC[i][16:9], VEC[i][8:1]);
      check($sformatf("R7/R8 vector %0d", i), int'(ovf), int'(VEC[i][0]));
    end

    strobe(8'h7F, 8'h00);
    repeat (6) @(negedge clk);
    check("R6 hold frozen without strobes", int'(ovf), 1);

    // restart while flagged
    restart(1'b0);
    check("R4 restart mutes", int'(mute), 1);
    check("R9 flag dropped on mute", int'(ovf), 0);

    // mode change during mute reloads long length
    strobes(3);
    @(negedge clk); dc = 1'b1;
    @(negedge clk);
    strobes(NL - 1);
    check("R5 reload after mode change", int'(mute), 1);
    strobe('0, '0);
    check("R5 long window ends", int'(mute), 0);

    // plain long window
    restart(1'b0);
    strobes(NL - 1);
    check("R3 long mute holds", int'(mute), 1);
    strobe('0, '0);
    check("R3 long mute released", int'(mute), 0);

    // mode change after mute: no effect
    @(negedge clk); dc = 1'b0;
    repeat (2) @(negedge clk);
    strobe('0, '0);
    check("R5 change after mute ignored", int'(mute), 0);

    // restart together with strobe: strobe not counted
    restart(1'b1);
    strobes(NS - 1);
    check("R4 coincident strobe not counted", int'(mute), 1);
    strobe('0, '0);
    check("R4/R2 short window after restart", int'(mute), 0);

    // hold cleared by restart does not reappear
    strobe(8'h71, 8'h00);
    check("R7 flag set", int'(ovf), 1);
    restart(1'b0);
    strobes(NS);
    check("R9 hold cleared by mute", int'(ovf), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule